// File: doc/BRIEF.md
# Segment Limit and Access Checker

This block vets one memory access against the currently selected segment before the address goes on to paging. Each request gives the linear address, the access size in bytes, write and execute flags, the segment's base, limit and three attribute bits, and four mode bits. The mode bits are protection enable, paging enable, long-mode active and code-segment long mode.

The checker first tests access rights, then compares the byte range against the segment bounds. It handles expand-up and expand-down segments. For both kinds it also covers a limit that sits below the base, which gives a wrapped segment. Real mode and 64-bit mode skip every check.

One cycle after the request strobe, a registered response reports one of two results:
- a general-protection fault with error code zero, or
- a pass, which then routes the access either to the translation buffer or straight out as a physical address equal to the linear one.

Top module: `seg_access_check`

## Requirements
- R1: `rsp_vld` is high exactly in the cycle after a cycle with `req_vld` high. While it is high, exactly one of `rsp_gp` and `rsp_ok` is high.
- R2: With `pe` low, the access passes whatever the attributes and bounds are. `rsp_pa_vld` is high, `rsp_pa` equals the request address, and `rsp_to_tlb` is low even when `pg` is high.
- R3: With `pe`, `lma` and `cs_long` all high, no segment check is made and the access passes. It goes to the translation buffer when `pg` is high, and to `rsp_pa` when `pg` is low.
- R4: In checked mode, a write (`is_wr` high) to a segment whose `seg_wr_ok` is low raises `rsp_gp`.
- R5: In checked mode, a data read (`is_wr` and `is_ex` both low) from a segment whose `seg_rd_ok` is low raises `rsp_gp`. An instruction fetch (`is_ex` high) is not blocked by `seg_rd_ok`.
- R6: Expand-up (`seg_xdown` low) with limit ≥ base faults exactly when limit < address + size.
- R7: Expand-up with limit < base faults exactly when limit < address + size and address < base.
- R8: Expand-down (`seg_xdown` high) with limit ≥ base faults exactly when address ≤ limit and address + size ≥ base.
- R9: Expand-down with limit < base faults exactly when address ≤ limit or address + size ≥ base.
- R10: In checked mode, a passing access with `pg` low gives `rsp_pa_vld` high and `rsp_pa` equal to the address. With `pg` high it gives `rsp_to_tlb` high and `rsp_pa_vld` low.
- R11: The sum address + size is formed one bit wider than the address, so an access that runs past the top of the address space is still caught by the limit compare. A fault always carries `rsp_err` = 0.
- R12: After reset, `rsp_vld`, `rsp_gp`, `rsp_ok`, `rsp_to_tlb` and `rsp_pa_vld` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Linear address |
| req_size | input | SIZE_W | Access size in bytes, 1 to MAX_SIZE |
| is_wr | input | 1 | Access is a write |
| is_ex | input | 1 | Access is an instruction fetch |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| seg_rd_ok | input | 1 | Segment readable |
| seg_wr_ok | input | 1 | Segment writable |
| seg_xdown | input | 1 | Segment expands down |
| pe | input | 1 | Protection enable |
| pg | input | 1 | Paging enable |
| lma | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment in long mode |
| rsp_vld | output | 1 | Response strobe |
| rsp_gp | output | 1 | General-protection fault |
| rsp_err | output | ERR_W | Fault error code, always zero |
| rsp_ok | output | 1 | Access passes |
| rsp_to_tlb | output | 1 | Passing access goes to translation lookup |
| rsp_pa_vld | output | 1 | `rsp_pa` holds the physical address |
| rsp_pa | output | ADDR_W | Physical address |

## Verification
A permission fault and a bounds fault can arise on the same request. The bench provokes this with a write to a read-only segment whose limit is also overrun, and expects exactly one fault with error code zero and no pass.

Mode bypass can likewise coincide with a segment that would fail every check. The bench drives such violating attributes in real mode and in 64-bit mode and expects a clean pass, routed according to the paging bit.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_PA   = 2'd1,
      ROUTE_TLB  = 2'd2
   } route_e;
endpackage

// File: rtl/seg_mode_dec.sv
module seg_mode_dec
   import seg_chk_pkg::*;
(
   input  logic   pe,
   input  logic   pg,
   input  logic   lma,
   input  logic   cs_long,
   output logic   bypass,
   output route_e route
);
   logic long64;

   always_comb begin
      long64 = pe & lma & cs_long;
      bypass = ~pe | long64;
      // Real mode never pages; protected mode pages when pg is set.
      if (pe && pg) route = ROUTE_TLB;
      else          route = ROUTE_PA;
   end
endmodule

// File: rtl/seg_perm_eval.sv
module seg_perm_eval (
   input  logic is_wr,
   input  logic is_ex,
   input  logic seg_rd_ok,
   input  logic seg_wr_ok,
   output logic perm_fault
);
   logic data_rd;

   always_comb begin
      data_rd    = ~is_wr & ~is_ex;
      perm_fault = (is_wr & ~seg_wr_ok) | (data_rd & ~seg_rd_ok);
   end
endmodule

// File: rtl/seg_bound_eval.sv
module seg_bound_eval #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] limit,
   input  logic              xdown,
   output logic              bound_fault
);
   localparam int SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] end_sum;
   logic [SUM_W-1:0] lim_x;
   logic [SUM_W-1:0] base_x;
   logic             wrapped;
   logic             up_fault;
   logic             dn_fault;

   generate
      if (SIZE_W < SUM_W) begin : g_pad
         assign end_sum = {1'b0, addr} + {{(SUM_W-SIZE_W){1'b0}}, size};
      end else begin : g_nopad
         assign end_sum = {1'b0, addr} + size[SUM_W-1:0];
      end
   endgenerate

   always_comb begin
      lim_x   = {1'b0, limit};
      base_x  = {1'b0, base};
      wrapped = limit < base;
      if (wrapped)
         up_fault = (lim_x < end_sum) && (addr < base);
      else
         up_fault = lim_x < end_sum;
      if (wrapped)
         dn_fault = (addr <= limit) || (end_sum >= base_x);
      else
         dn_fault = (addr <= limit) && (end_sum >= base_x);
      bound_fault = xdown ? dn_fault : up_fault;
   end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
   import seg_chk_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MAX_SIZE = 8,
   parameter int ERR_W    = 16,
   parameter int SIZE_W   = $clog2(MAX_SIZE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              is_wr,
   input  logic              is_ex,
   input  logic [ADDR_W-1:0] seg_base,
   input  logic [ADDR_W-1:0] seg_limit,
   input  logic              seg_rd_ok,
   input  logic              seg_wr_ok,
   input  logic              seg_xdown,
   input  logic              pe,
   input  logic              pg,
   input  logic              lma,
   input  logic              cs_long,
   output logic              rsp_vld,
   output logic              rsp_gp,
   output logic [ERR_W-1:0]  rsp_err,
   output logic              rsp_ok,
   output logic              rsp_to_tlb,
   output logic              rsp_pa_vld,
   output logic [ADDR_W-1:0] rsp_pa
);
   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
      if (MAX_SIZE < 1) begin : g_bad_size
         $error("MAX_SIZE must be at least 1");
      end
      if (ERR_W < 1) begin : g_bad_err
         $error("ERR_W must be at least 1");
      end
   endgenerate

   logic   bypass;
   route_e route;
   logic   perm_fault;
   logic   bound_fault;
   logic   fault_c;

   seg_mode_dec u_mode (
      .pe      (pe),
      .pg      (pg),
      .lma     (lma),
      .cs_long (cs_long),
      .bypass  (bypass),
      .route   (route)
   );

   seg_perm_eval u_perm (
      .is_wr      (is_wr),
      .is_ex      (is_ex),
      .seg_rd_ok  (seg_rd_ok),
      .seg_wr_ok  (seg_wr_ok),
      .perm_fault (perm_fault)
   );

   seg_bound_eval #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bound (
      .addr        (req_addr),
      .size        (req_size),
      .base        (seg_base),
      .limit       (seg_limit),
      .xdown       (seg_xdown),
      .bound_fault (bound_fault)
   );

   assign fault_c = ~bypass & (perm_fault | bound_fault);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld    <= 1'b0;
         rsp_gp     <= 1'b0;
         rsp_ok     <= 1'b0;
         rsp_to_tlb <= 1'b0;
         rsp_pa_vld <= 1'b0;
         rsp_pa     <= '0;
      end else begin
         rsp_vld    <= req_vld;
         rsp_gp     <= req_vld & fault_c;
         rsp_ok     <= req_vld & ~fault_c;
         rsp_to_tlb <= req_vld & ~fault_c & (route == ROUTE_TLB);
         rsp_pa_vld <= req_vld & ~fault_c & (route == ROUTE_PA);
         if (req_vld) rsp_pa <= req_addr;
      end
   end

   assign rsp_err = '0;

   a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);
   a_r1_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld);
   a_r1_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> $countones({rsp_gp, rsp_ok}) == 1);
   a_r2_real_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !pe) |=> (rsp_ok && rsp_pa_vld && !rsp_to_tlb));
   a_r3_long_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && pe && lma && cs_long) |=> rsp_ok);
   a_r4_write_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && pe && !(lma && cs_long) && is_wr && !seg_wr_ok) |=> rsp_gp);
   a_r10_route_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_to_tlb && rsp_pa_vld));
   a_r10_pa_copy: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_pa == $past(req_addr));
endmodule

// File: tb/seg_access_check_test.sv
module seg_access_check_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic        is_wr = 1'b0, is_ex = 1'b0;
   logic [31:0] seg_base = '0, seg_limit = '0;
   logic        seg_rd_ok = 1'b0, seg_wr_ok = 1'b0, seg_xdown = 1'b0;
   logic        pe = 1'b0, pg = 1'b0, lma = 1'b0, cs_long = 1'b0;
   logic        rsp_vld, rsp_gp, rsp_ok, rsp_to_tlb, rsp_pa_vld;
   logic [15:0] rsp_err;
   logic [31:0] rsp_pa;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_access_check uut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
      .req_size(req_size), .is_wr(is_wr), .is_ex(is_ex),
      .seg_base(seg_base), .seg_limit(seg_limit), .seg_rd_ok(seg_rd_ok),
      .seg_wr_ok(seg_wr_ok), .seg_xdown(seg_xdown), .pe(pe), .pg(pg),
      .lma(lma), .cs_long(cs_long), .rsp_vld(rsp_vld), .rsp_gp(rsp_gp),
      .rsp_err(rsp_err), .rsp_ok(rsp_ok), .rsp_to_tlb(rsp_to_tlb),
      .rsp_pa_vld(rsp_pa_vld), .rsp_pa(rsp_pa)
   );

   typedef struct packed {
      logic        pe, pg, lma, csl, wr, ex, rd, wo, xd;
      logic [31:0] addr;
      logic [3:0]  sz;
      logic [31:0] base, lim;
      logic        gp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      // R2: real mode, violating segment
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h1000,4'd4, 32'h20,32'h10, 1'b0, 8'd2},
      '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0800,4'd8, 32'h10,32'h4000, 1'b0, 8'd2},
      // R3: 64-bit mode, paging on and off
      '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h5000,4'd4, 32'h0,32'h10, 1'b0, 8'd3},
      '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h5000,4'd4, 32'h0,32'h10, 1'b0, 8'd3},
      // R4: write permission
      '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h0100,4'd4, 32'h0,32'hFFFF_FFFF, 1'b1, 8'd4},
      '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 32'h0100,4'd4, 32'h0,32'hFFFF_FFFF, 1'b0, 8'd4},
      // R5: read permission; fetch unaffected
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0100,4'd2, 32'h0,32'hFFFF_FFFF, 1'b1, 8'd5},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0100,4'd2, 32'h0,32'hFFFF_FFFF, 1'b0, 8'd5},
      // R6: expand-up, normal
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'h1FFC,4'd4, 32'h1000,32'h1FFF, 1'b1, 8'd6},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'h1FFB,4'd4, 32'h1000,32'h1FFF, 1'b0, 8'd6},
      // R7: expand-up, wrapped
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0FFE,4'd4, 32'h8000,32'h1000, 1'b1, 8'd7},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'h9000,4'd8, 32'h8000,32'h1000, 1'b0, 8'd7},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0FF0,4'd4, 32'h8000,32'h1000, 1'b0, 8'd7},
      // R8: expand-down, normal
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h2000,4'd4, 32'h1000,32'h4000, 1'b1, 8'd8},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h5000,4'd4, 32'h1000,32'h4000, 1'b0, 8'd8},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h0F00,4'd4, 32'h1000,32'h4000, 1'b0, 8'd8},
      // R9: expand-down, wrapped
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h0800,4'd4, 32'h8000,32'h1000, 1'b1, 8'd9},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h7FF8,4'd8, 32'h8000,32'h1000, 1'b1, 8'd9},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h4000,4'd4, 32'h8000,32'h1000, 1'b0, 8'd9},
      // R10: checked mode with paging on goes to the translation buffer
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0400,4'd1, 32'h0,32'hFFFF, 1'b0, 8'd10},
      // R11: wide sum catches overrun past the top of the space
      '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'hFFFF_FFFC,4'd8, 32'h0,32'hFFFF_FFFF, 1'b1, 8'd11},
      // R4 with R6 together: permission and bound fault on one request
      '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h1FFE,4'd4, 32'h1000,32'h1FFF, 1'b1, 8'd4}
   };

   task automatic chk(input bit ok, input int req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      req_vld = 1'b1; req_addr = v.addr; req_size = v.sz;
      is_wr = v.wr; is_ex = v.ex; seg_base = v.base; seg_limit = v.lim;
      seg_rd_ok = v.rd; seg_wr_ok = v.wo; seg_xdown = v.xd;
      pe = v.pe; pg = v.pg; lma = v.lma; cs_long = v.csl;
   endtask

   task automatic judge(input vec_t v);
      logic etlb, epa;
      etlb = !v.gp && v.pe && v.pg;
      epa  = !v.gp && !(v.pe && v.pg);
      chk(rsp_vld == 1'b1, 1, "rsp_vld", 64'(rsp_vld), 64'd1);
      chk(rsp_gp == v.gp, int'(v.req), "rsp_gp", 64'(rsp_gp), 64'(v.gp));
      chk(rsp_ok == !v.gp, 1, "rsp_ok", 64'(rsp_ok), 64'(!v.gp));
      chk(rsp_to_tlb == etlb, 10, "rsp_to_tlb", 64'(rsp_to_tlb), 64'(etlb));
      chk(rsp_pa_vld == epa, 10, "rsp_pa_vld", 64'(rsp_pa_vld), 64'(epa));
      if (epa) chk(rsp_pa == v.addr, 10, "rsp_pa", 64'(rsp_pa), 64'(v.addr));
      if (v.gp) chk(rsp_err == 16'd0, 11, "rsp_err", 64'(rsp_err), 64'd0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL R1 watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R12: reset state
      chk({rsp_vld, rsp_gp, rsp_ok, rsp_to_tlb, rsp_pa_vld} == 5'b0, 12,
          "reset outputs", 64'({rsp_vld, rsp_gp, rsp_ok, rsp_to_tlb, rsp_pa_vld}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: no response without a request
      chk(rsp_vld == 1'b0, 1, "idle rsp_vld", 64'(rsp_vld), 64'd0);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         @(negedge clk);
         req_vld = 1'b0;
         judge(VECS[i]);
         @(negedge clk);
         // R1: strobe drops after a single request
         chk(rsp_vld == 1'b0, 1, "rsp_vld after gap", 64'(rsp_vld), 64'd0);
      end

      // R1: back-to-back requests, each answered the next cycle
      apply(VECS[8]);
      @(negedge clk);
      judge(VECS[8]);
      req_vld = 1'b1; req_addr = VECS[9].addr; req_size = VECS[9].sz;
      @(negedge clk);
      req_vld = 1'b0;
      judge(VECS[9]);

      // R12: reset mid-stream clears the response
      apply(VECS[4]);
      rst_n = 1'b0;
      @(negedge clk);
      req_vld = 1'b0;
      chk(rsp_vld == 1'b0 && rsp_gp == 1'b0, 12, "reset clears", 64'({rsp_vld, rsp_gp}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule